// File: doc/BRIEF.md
# Multi-mode interrupt acknowledge controller

This block sits beside the control unit of an 8-bit processor core and decides where execution goes when an interrupt is taken. It watches a level-sensitive maskable request and an edge-sensitive non-maskable request. At each instruction boundary it either starts a service or lets execution carry on. It holds the two interrupt-enable flags, a 2-bit response mode and an 8-bit vector base register. The instruction decoder drives these through single-cycle strobes for enable, disable, return-from-NMI, mode write and base write.

A non-maskable service is started at once to a fixed address, with no bus cycle. A maskable service first runs a one-cycle acknowledge, in which both `ack_m1` and `ack_iorq` are high and the responding peripheral puts a byte on `bus_din`. Mode 0 treats that byte as a restart opcode. Mode 1 ignores it and jumps to a fixed address. Mode 2 combines it with the base register into a table pointer, reads a little-endian 16-bit target in two one-cycle table reads, and jumps there. Every service ends with a one-cycle `svc_start` strobe that carries the target on `svc_addr`.

Top module: `iack_ctrl`

## Requirements
- R1: After reset both enable flags, the mode register (value 0) and the vector base register (value 0x00) are cleared, and `ack_m1`, `ack_iorq`, `tbl_rd` and `svc_start` are low.
- R2: A maskable request is accepted only when the block is idle, `insn_end` is high, `irq` is high, enable flag 1 is set and no non-maskable request is pending. Acceptance clears both flags. In the next cycle, and only in that cycle, `ack_m1` and `ack_iorq` are both high.
- R3: In mode 0 the byte on `bus_din` during the acknowledge cycle is a restart opcode. In the following cycle `svc_start` pulses with `svc_addr` = bits 5:3 of that byte times 8.
- R4: In mode 1 the byte during the acknowledge cycle has no effect. In the following cycle `svc_start` pulses with `svc_addr` = 0x0038.
- R5: In mode 2 the two cycles after the acknowledge are table reads (`tbl_rd` high). The first reads address {base register, acknowledge byte with bit 0 cleared} and the second reads that address plus 1. The byte read in the first is the low half of the target and the byte read in the second is the high half. `svc_start` pulses with that target in the cycle after the second read.
- R6: A rising edge on `nmi` is held pending. At the next `insn_end` while idle, it is serviced ahead of any maskable request. `svc_start` pulses in the next cycle with `svc_addr` = 0x0066 and no acknowledge cycle. Flag 2 takes the old value of flag 1, and flag 1 is cleared.
- R7: `ei_set` sets both flags and `di_clr` clears both; `di_clr` wins if both are high. `retn` copies flag 2 into flag 1. These strobes have no effect in a cycle where an interrupt is taken.
- R8: `mode_wr` loads `mode_val` (0, 1 or 2) into the mode register. A write of 3 leaves the mode unchanged. The mode in force at acceptance governs the whole service, even if it is rewritten later.
- R9: At most one of the acknowledge, a table read and `svc_start` is active in any cycle. No new interrupt is taken while a service is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_end | input | 1 | Instruction boundary strobe |
| irq | input | 1 | Maskable request, level |
| nmi | input | 1 | Non-maskable request, rising edge |
| ei_set | input | 1 | Enable-interrupts strobe |
| di_clr | input | 1 | Disable-interrupts strobe |
| retn | input | 1 | Return-from-NMI strobe: flag 1 gets flag 2 |
| mode_wr | input | 1 | Mode write strobe |
| mode_val | input | 2 | New mode value |
| ireg_wr | input | 1 | Vector base write strobe |
| ireg_val | input | 8 | New vector base value |
| bus_din | input | 8 | Data bus byte during acknowledge and table reads |
| ack_m1 | output | 1 | Acknowledge, opcode-fetch marker |
| ack_iorq | output | 1 | Acknowledge, I/O request marker |
| tbl_rd | output | 1 | Vector table read in progress |
| tbl_addr | output | 16 | Vector table read address |
| svc_start | output | 1 | One-cycle start-of-service strobe |
| svc_addr | output | 16 | Service target address, valid with `svc_start` |
| iff1 | output | 1 | Enable flag 1 |
| iff2 | output | 1 | Enable flag 2 |

## Verification
Each mode is driven with acknowledge bytes chosen to tell the modes apart. A restart opcode whose other bits are set shows that mode 0 extracts only bits 5:3. An all-ones byte in mode 1 shows that the bus is ignored. An odd vector byte in mode 2 shows that bit 0 is forced low and that the two table bytes are joined in little-endian order. Further patterns apply an NMI edge while a maskable request is also waiting, then a return-from-NMI, to tell priority apart from flag restoration. A mode write of 3 and a rewrite during a service show that the mode register is protected and that the mode is latched at acceptance. Enable strobes and boundaries raised mid-service show that nothing is accepted until the block is idle again.

// File: rtl/iack_pkg.sv
package iack_pkg;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int MW = 2;

    localparam logic [MW-1:0] MODE_RST   = 2'd0;
    localparam logic [MW-1:0] MODE_FIXED = 2'd1;
    localparam logic [MW-1:0] MODE_TABLE = 2'd2;
    localparam logic [MW-1:0] MODE_BAD   = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACK  = 2'd1,
        ST_TLO  = 2'd2,
        ST_THI  = 2'd3
    } iack_state_e;

    typedef struct packed {
        logic iff1;
        logic iff2;
        logic nmi_prev;
        logic nmi_pend;
    } flags_t;

    typedef struct packed {
        logic [MW-1:0] mode;
        logic [DW-1:0] ireg;
    } cfg_t;

    typedef struct packed {
        iack_state_e   st;
        logic [MW-1:0] smode;
        logic [AW-1:0] ptr;
        logic [DW-1:0] lo;
        logic          start;
        logic [AW-1:0] addr;
    } ctl_t;
endpackage

// File: rtl/iack_flags.sv
module iack_flags
    import iack_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nmi,
    input  logic take_nmi,
    input  logic take_irq,
    input  logic ei_set,
    input  logic di_clr,
    input  logic retn,
    output logic iff1,
    output logic iff2,
    output logic nmi_pend
);
    flags_t fl_d, fl_q;
    logic   nmi_edge;

    always_comb begin
        fl_d          = fl_q;
        nmi_edge      = nmi & ~fl_q.nmi_prev;
        fl_d.nmi_prev = nmi;
        if (take_nmi) begin
            fl_d.iff2     = fl_q.iff1;
            fl_d.iff1     = 1'b0;
            fl_d.nmi_pend = 1'b0;
        end else if (take_irq) begin
            fl_d.iff1 = 1'b0;
            fl_d.iff2 = 1'b0;
        end else if (di_clr) begin
            fl_d.iff1 = 1'b0;
            fl_d.iff2 = 1'b0;
        end else if (ei_set) begin
            fl_d.iff1 = 1'b1;
            fl_d.iff2 = 1'b1;
        end else if (retn) begin
            fl_d.iff1 = fl_q.iff2;
        end
        fl_d.nmi_pend = fl_d.nmi_pend | nmi_edge;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign iff1     = fl_q.iff1;
    assign iff2     = fl_q.iff2;
    assign nmi_pend = fl_q.nmi_pend;

    p_irq_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> (!iff1 && !iff2));
    p_nmi_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        take_nmi |=> (!iff1 && iff2 == $past(iff1)));
    p_di_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (di_clr && !take_nmi && !take_irq) |=> (!iff1 && !iff2));
endmodule

// File: rtl/iack_cfg.sv
module iack_cfg
    import iack_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_wr,
    input  logic [MW-1:0] mode_val,
    input  logic          ireg_wr,
    input  logic [DW-1:0] ireg_val,
    output logic [MW-1:0] mode,
    output logic [DW-1:0] ireg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (mode_wr && mode_val != MODE_BAD) cfg_d.mode = mode_val;
        if (ireg_wr) cfg_d.ireg = ireg_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '{mode: MODE_RST, ireg: '0};
        else        cfg_q <= cfg_d;
    end

    assign mode = cfg_q.mode;
    assign ireg = cfg_q.ireg;

    p_mode_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode != MODE_BAD);
endmodule

// File: rtl/iack_target.sv
module iack_target
    import iack_pkg::*;
#(
    parameter logic [AW-1:0] FIX_VEC = 16'h0038
) (
    input  logic [MW-1:0] smode,
    input  logic [DW-1:0] ack_byte,
    input  logic [DW-1:0] ireg,
    output logic [AW-1:0] fix_tgt,
    output logic [AW-1:0] tbl_ptr
);
    localparam int RST_LSB = 3;
    localparam int RST_W   = 3;

    always_comb begin
        if (smode == MODE_RST)
            fix_tgt = {{(AW-RST_W-RST_LSB){1'b0}},
                       ack_byte[RST_LSB+RST_W-1:RST_LSB], {RST_LSB{1'b0}}};
        else
            fix_tgt = FIX_VEC;
        tbl_ptr = {ireg, ack_byte[DW-1:1], 1'b0};
    end
endmodule

// File: rtl/iack_ctrl.sv
module iack_ctrl
    import iack_pkg::*;
#(
    parameter logic [AW-1:0] NMI_VEC = 16'h0066,
    parameter logic [AW-1:0] FIX_VEC = 16'h0038
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          insn_end,
    input  logic          irq,
    input  logic          nmi,
    input  logic          ei_set,
    input  logic          di_clr,
    input  logic          retn,
    input  logic          mode_wr,
    input  logic [MW-1:0] mode_val,
    input  logic          ireg_wr,
    input  logic [DW-1:0] ireg_val,
    input  logic [DW-1:0] bus_din,
    output logic          ack_m1,
    output logic          ack_iorq,
    output logic          tbl_rd,
    output logic [AW-1:0] tbl_addr,
    output logic          svc_start,
    output logic [AW-1:0] svc_addr,
    output logic          iff1,
    output logic          iff2
);
    ctl_t          c_d, c_q;
    logic          nmi_pend, take_nmi, take_irq, idle;
    logic [MW-1:0] mode;
    logic [DW-1:0] ireg;
    logic [AW-1:0] fix_tgt, tbl_ptr;

    assign idle     = (c_q.st == ST_IDLE);
    assign take_nmi = idle && insn_end && nmi_pend;
    assign take_irq = idle && insn_end && irq && iff1 && !nmi_pend;

    iack_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi      (nmi),
        .take_nmi (take_nmi),
        .take_irq (take_irq),
        .ei_set   (ei_set),
        .di_clr   (di_clr),
        .retn     (retn),
        .iff1     (iff1),
        .iff2     (iff2),
        .nmi_pend (nmi_pend)
    );

    iack_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_wr  (mode_wr),
        .mode_val (mode_val),
        .ireg_wr  (ireg_wr),
        .ireg_val (ireg_val),
        .mode     (mode),
        .ireg     (ireg)
    );

    iack_target #(.FIX_VEC(FIX_VEC)) u_target (
        .smode    (c_q.smode),
        .ack_byte (bus_din),
        .ireg     (ireg),
        .fix_tgt  (fix_tgt),
        .tbl_ptr  (tbl_ptr)
    );

    always_comb begin
        c_d       = c_q;
        c_d.start = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (take_nmi) begin
                    c_d.start = 1'b1;
                    c_d.addr  = NMI_VEC;
                end else if (take_irq) begin
                    c_d.st    = ST_ACK;
                    c_d.smode = mode;
                end
            end
            ST_ACK: begin
                if (c_q.smode == MODE_TABLE) begin
                    c_d.ptr = tbl_ptr;
                    c_d.st  = ST_TLO;
                end else begin
                    c_d.start = 1'b1;
                    c_d.addr  = fix_tgt;
                    c_d.st    = ST_IDLE;
                end
            end
            ST_TLO: begin
                c_d.lo = bus_din;
                c_d.st = ST_THI;
            end
            ST_THI: begin
                c_d.start = 1'b1;
                c_d.addr  = {bus_din, c_q.lo};
                c_d.st    = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, smode: MODE_RST, ptr: '0, lo: '0,
                             start: 1'b0, addr: '0};
        else        c_q <= c_d;
    end

    assign ack_m1    = (c_q.st == ST_ACK);
    assign ack_iorq  = (c_q.st == ST_ACK);
    assign tbl_rd    = (c_q.st == ST_TLO) || (c_q.st == ST_THI);
    assign tbl_addr  = c_q.ptr + AW'(c_q.st == ST_THI);
    assign svc_start = c_q.start;
    assign svc_addr  = c_q.addr;

    p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_m1 |=> !ack_m1);
    p_ack_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_m1) |-> (!iff1 && !iff2));
    p_fixed_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_start && $past(ack_m1) && $past(c_q.smode) == MODE_FIXED)
            |-> svc_addr == FIX_VEC);
    p_tbl_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_TLO) |-> !tbl_addr[0]);
    p_tbl_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_TLO) |=> (tbl_rd && tbl_addr == $past(tbl_addr) + 16'd1));
    p_nmi_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_start && $past(c_q.st) == ST_IDLE) |-> svc_addr == NMI_VEC);
    p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack_m1, tbl_rd, svc_start}));
endmodule

// File: tb/test_iack_ctrl.sv
module test_iack_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_end = 0, irq = 0, nmi = 0, ei_set = 0, di_clr = 0, retn = 0;
    logic        mode_wr = 0, ireg_wr = 0;
    logic [1:0]  mode_val = 0;
    logic [7:0]  ireg_val = 0, vec_byte = 0, bus_din;
    logic        ack_m1, ack_iorq, tbl_rd, svc_start, iff1, iff2;
    logic [15:0] tbl_addr, svc_addr;

    int n_chk = 0, n_bad = 0, cyc = 0;
    string cur_req = "R1";
    bit    run_cmp = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    // peripheral and vector table seen by the block
    always_comb begin
        if (ack_m1)      bus_din = vec_byte;
        else if (tbl_rd) bus_din = mem_byte(tbl_addr);
        else             bus_din = 8'hA7;
    end

    iack_ctrl i_iack_ctrl (
        .clk(clk), .rst_n(rst_n), .insn_end(insn_end), .irq(irq), .nmi(nmi),
        .ei_set(ei_set), .di_clr(di_clr), .retn(retn), .mode_wr(mode_wr),
        .mode_val(mode_val), .ireg_wr(ireg_wr), .ireg_val(ireg_val),
        .bus_din(bus_din), .ack_m1(ack_m1), .ack_iorq(ack_iorq),
        .tbl_rd(tbl_rd), .tbl_addr(tbl_addr), .svc_start(svc_start),
        .svc_addr(svc_addr), .iff1(iff1), .iff2(iff2)
    );

    // behavioural reference
    int          m_phase = 0;
    bit          m_f1 = 0, m_f2 = 0, m_prev = 0, m_pend = 0;
    int          m_mode = 0, m_smode = 0;
    logic [7:0]  m_i = 0, m_lo = 0;
    logic [15:0] m_ptr = 0, e_addr = 0;
    bit          e_start = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_f1 = 0; m_f2 = 0; m_prev = 0; m_pend = 0;
            m_mode = 0; m_smode = 0; m_i = 0; e_start = 0;
        end else begin
            bit edge_seen, taken;
            edge_seen = nmi && !m_prev;
            m_prev = nmi;
            e_start = 0;
            taken = 0;
            case (m_phase)
                0: if (insn_end && m_pend) begin
                       e_start = 1; e_addr = 16'h0066;
                       m_f2 = m_f1; m_f1 = 0; m_pend = 0; taken = 1;
                   end else if (insn_end && irq && m_f1) begin
                       m_f1 = 0; m_f2 = 0; m_smode = m_mode; m_phase = 1; taken = 1;
                   end
                1: if (m_smode == 2) begin
                       m_ptr = {m_i, vec_byte & 8'hFE}; m_phase = 2;
                   end else begin
                       e_start = 1;
                       e_addr = (m_smode == 0) ? 16'(int'(vec_byte[5:3]) * 8) : 16'h0038;
                       m_phase = 0;
                   end
                2: begin m_lo = mem_byte(m_ptr); m_phase = 3; end
                default: begin
                    e_start = 1; e_addr = {mem_byte(m_ptr + 16'd1), m_lo}; m_phase = 0;
                end
            endcase
            if (!taken) begin
                if (di_clr)      begin m_f1 = 0; m_f2 = 0; end
                else if (ei_set) begin m_f1 = 1; m_f2 = 1; end
                else if (retn)   m_f1 = m_f2;
            end
            if (edge_seen) m_pend = 1;
            if (mode_wr && mode_val != 2'd3) m_mode = int'(mode_val);
            if (ireg_wr) m_i = ireg_val;
        end
    end

    task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at cycle %0d", cur_req, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (run_cmp) begin
            chk("ack_m1",    16'(ack_m1),    16'(m_phase == 1));
            chk("ack_iorq",  16'(ack_iorq),  16'(m_phase == 1));
            chk("tbl_rd",    16'(tbl_rd),    16'(m_phase >= 2));
            if (m_phase >= 2) chk("tbl_addr", tbl_addr, m_ptr + 16'(m_phase == 3));
            chk("svc_start", 16'(svc_start), 16'(e_start));
            if (e_start) chk("svc_addr", svc_addr, e_addr);
            chk("iff1",      16'(iff1),      16'(m_f1));
            chk("iff2",      16'(iff2),      16'(m_f2));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_clear();
        insn_end = 0; ei_set = 0; di_clr = 0; retn = 0; mode_wr = 0; ireg_wr = 0;
    endtask

    task automatic boundary();
        insn_end = 1; step(1); pulse_clear();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1;
        step(1);
        cur_req = "R1";
        chk("reset iff1", 16'(iff1), 16'h0);
        chk("reset iff2", 16'(iff2), 16'h0);
        chk("reset start", 16'(svc_start), 16'h0);
        chk("reset ack", 16'(ack_m1 | tbl_rd), 16'h0);
        run_cmp = 1;

        // R2: request with flags clear is not taken
        cur_req = "R2"; irq = 1; boundary(); step(3);
        // R7: enable, disable, both
        cur_req = "R7"; ei_set = 1; step(1); pulse_clear(); step(1);
        di_clr = 1; step(1); pulse_clear(); step(1);
        ei_set = 1; di_clr = 1; step(1); pulse_clear(); step(1);
        // R1/R3: mode 0 from reset, restart opcode 0xEF -> 0x0028
        cur_req = "R3"; vec_byte = 8'hEF; ei_set = 1; step(1); pulse_clear();
        ei_set = 1; insn_end = 1; step(1); pulse_clear(); step(4);
        // R2: no acceptance without boundary
        cur_req = "R2"; ei_set = 1; step(1); pulse_clear(); step(3);
        // R4: mode 1 ignores the bus
        cur_req = "R4"; mode_val = 2'd1; mode_wr = 1; step(1); pulse_clear();
        vec_byte = 8'hFF; boundary(); step(4);
        // R5: mode 2 with odd vector byte
        cur_req = "R5"; mode_val = 2'd2; mode_wr = 1; ireg_val = 8'h12; ireg_wr = 1;
        ei_set = 1; step(1); pulse_clear();
        vec_byte = 8'h35; boundary(); step(6);
        // R8: write of 3 ignored, mode stays 2
        cur_req = "R8"; mode_val = 2'd3; mode_wr = 1; ei_set = 1; step(1); pulse_clear();
        vec_byte = 8'hC0; boundary();
        // R8: rewrite during service does not change the running one
        mode_val = 2'd0; mode_wr = 1; step(1); pulse_clear();
        // R9: boundary and enable mid-service are not new acceptances
        cur_req = "R9"; ei_set = 1; insn_end = 1; step(1); pulse_clear();
        insn_end = 1; step(1); pulse_clear(); step(4);
        // R6: NMI edge while maskable also waiting
        cur_req = "R6"; di_clr = 1; step(1); pulse_clear();
        ei_set = 1; step(1); pulse_clear();
        nmi = 1; step(2); boundary(); step(2);
        nmi = 0; step(1);
        // R7: retn restores flag 1, then maskable taken in mode 0
        cur_req = "R7"; retn = 1; step(1); pulse_clear(); step(1);
        vec_byte = 8'h38; boundary(); step(4);
        // R6: NMI with flags clear keeps flag 2 low
        cur_req = "R6"; nmi = 1; step(1); boundary(); nmi = 0; step(3);
        // R6: NMI edge during a service waits for idle
        ei_set = 1; step(1); pulse_clear();
        mode_val = 2'd2; mode_wr = 1; step(1); pulse_clear();
        vec_byte = 8'h7E; boundary(); nmi = 1; step(1); nmi = 0;
        insn_end = 1; step(1); pulse_clear(); step(2);
        boundary(); step(4);

        run_cmp = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule